// File: doc/BRIEF.md
# DMA Peripheral Cycle Engine for a 4-bit LPC Bus

This block is the peripheral end of DMA transfers on a 4-bit LPC bus. It watches the frame strobe and the 4-bit bus for a start nibble. It then decodes the cycle that follows: the cycle type and direction, the channel number together with its terminal-count flag, and the transfer size.

For host-to-peripheral transfers, the engine collects each data byte from two nibbles, low nibble first. It waits out the host's two-clock turnaround and answers with a SYNC nibble. For peripheral-to-host transfers, which include verify cycles, it waits out the host turnaround, drives SYNC and then drives the byte.

On the local side the engine has two byte-wide, queue-style ports:
- a push port for received bytes, throttled by a ready input;
- a pop port for bytes to send, offered with a valid flag.

While the local side is not ready, the engine keeps the host waiting with short-wait SYNC nibbles. It also raises a one-hot acknowledge line for the channel being served. The terminal-count flag captured with the channel is passed to the local side only with the final byte that the size implies.

Top module: `lpc_dma_periph`

## Requirements
- R1: After synchronous reset, and whenever the engine is idle, `lad_oe`, `rx_push`, `tx_pop`, `rx_tc`, `tx_tc` and every bit of `chan_ack` are 0.
- R2: A clock with `lframe_n` low and `lad_in` = 0000 is a start. A clock with `lframe_n` low and any other nibble returns the engine to idle. The cycle-type field is the first clock with `lframe_n` high after a start.
- R3: The cycle-type nibble is DMA when bits [3:2] = 10. Bit [1] = 0 selects host-to-peripheral and bit [1] = 1 selects peripheral-to-host (write or verify). Any other type makes the engine ignore the cycle and never drive the bus.
- R4: In the channel field, bits [2:0] give the channel and bit [3] gives the terminal-count flag. A channel number of NCH or above is ignored. For a served channel, `chan_ack` is one-hot on that channel from the size-field clock through the final release clock.
- R5: Size nibble bits [1:0] = 00 move one byte and 01 move two bytes. Any other size ends the cycle with no bus drive.
- R6: Host-to-peripheral flow: the data low nibble, then the high nibble, then two host turnaround clocks, then one SYNC clock driven by the engine. In the ready-SYNC clock (0000), `rx_push` is 1 and `rx_data` holds the assembled byte.
- R7: During a SYNC clock the engine drives 0101 (short wait) while its local side is not ready. The local side is not ready when `rx_ready` = 0 for receive or `tx_valid` = 0 for send. The engine drives 0000 in the first clock after it samples ready.
- R8: Peripheral-to-host flow: two host turnaround clocks after the size field, then SYNC. In the ready-SYNC clock `tx_pop` is 1. The next two clocks carry `tx_data` low nibble and then high nibble. For two bytes the SYNC and data sequence repeats.
- R9: After each receive SYNC, and after the last sent byte, the engine drives 1111 for one clock and then releases `lad_oe`. In a two-byte receive, the host's second data byte follows the release clock.
- R10: `rx_tc` and `tx_tc` are 1 only together with the push or pop of the last byte, and only when the captured terminal-count flag is 1.
- R11: `lframe_n` low in the middle of a cycle releases the bus on the next clock. A partly received byte is never pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| lframe_n | input | 1 | Frame strobe, active low |
| lad_in | input | 4 | Nibble sampled from the bus |
| lad_out | output | 4 | Nibble driven onto the bus |
| lad_oe | output | 1 | Bus drive enable |
| rx_ready | input | 1 | Local receive queue can accept a byte |
| rx_push | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| rx_tc | output | 1 | Terminal count with the received byte |
| tx_valid | input | 1 | Local send queue has a byte |
| tx_data | input | 8 | Head byte of the send queue |
| tx_pop | output | 1 | Send byte taken strobe |
| tx_tc | output | 1 | Terminal count with the sent byte |
| chan_ack | output | NCH | One-hot active channel |

## Verification
The hardest situation to reach is a two-byte transfer in which only the second byte carries the terminal count and the engine holds the host with short-wait SYNCs. The stimulus produces this by withholding `rx_ready` or `tx_valid` for a few SYNC clocks on one byte of a two-byte cycle with the terminal-count flag set. It then checks that the flag appears only with the last byte and that the first byte is neither lost nor pushed twice. A second difficult case is an abort that lands after half a byte has arrived, or during a wait SYNC. The bench creates it by pulling the frame strobe low at those exact clocks and then counting pushes and pops.

// File: rtl/lpc_dma_pkg.sv
package lpc_dma_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CTYPE, ST_CHAN, ST_SIZE,
    ST_HDL, ST_HDH, ST_HTA1, ST_HTA2,
    ST_SYNC, ST_PDL, ST_PDH, ST_PTA1, ST_PTA2
  } lpc_st_e;

  localparam logic [3:0] NIB_START  = 4'h0;
  localparam logic [3:0] NIB_TURN   = 4'hF;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_SWAIT = 4'h5;
  localparam logic [1:0] CT_DMA     = 2'b10;
  localparam logic [1:0] SZ_ONE     = 2'b00;
  localparam logic [1:0] SZ_TWO     = 2'b01;
endpackage

// File: rtl/lpc_dma_fsm.sv
module lpc_dma_fsm import lpc_dma_pkg::*; #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lframe_n,
  input  logic [3:0]     lad_in,
  input  logic           rx_ready,
  input  logic           tx_valid,
  output lpc_st_e        state,
  output lpc_st_e        nxt,
  output logic           take,
  output logic           dir_wr,
  output logic           last_tc,
  output logic [NCH-1:0] chan_ack
);
  localparam int FW = 3;

  lpc_st_e        state_q;
  logic           dir_q, tc_q, two_q, sync_ok_q;
  logic [1:0]     done_q;
  logic [FW-1:0]  chan_q;
  logic           rdy, more, active;
  logic [FW-1:0]  sel;

  assign rdy  = dir_q ? tx_valid : rx_ready;
  assign more = done_q < ({1'b0, two_q} + 2'd1);

  always_comb begin
    nxt = state_q;
    if (!lframe_n) begin
      nxt = (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  nxt = ST_IDLE;
        ST_CTYPE: nxt = (lad_in[3:2] == CT_DMA) ? ST_CHAN : ST_IDLE;
        ST_CHAN:  nxt = (int'(lad_in[2:0]) < NCH) ? ST_SIZE : ST_IDLE;
        ST_SIZE:  nxt = (lad_in[1:0] == SZ_ONE || lad_in[1:0] == SZ_TWO)
                        ? (dir_q ? ST_HTA1 : ST_HDL) : ST_IDLE;
        ST_HDL:   nxt = ST_HDH;
        ST_HDH:   nxt = ST_HTA1;
        ST_HTA1:  nxt = ST_HTA2;
        ST_HTA2:  nxt = ST_SYNC;
        ST_SYNC:  nxt = sync_ok_q ? (dir_q ? ST_PDL : ST_PTA1) : ST_SYNC;
        ST_PDL:   nxt = ST_PDH;
        ST_PDH:   nxt = more ? ST_SYNC : ST_PTA1;
        ST_PTA1:  nxt = ST_PTA2;
        ST_PTA2:  nxt = (!dir_q && more) ? ST_HDL : ST_IDLE;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  assign take    = (nxt == ST_SYNC) && rdy;
  assign last_tc = tc_q && (done_q == {1'b0, two_q});
  assign state   = state_q;
  assign dir_wr  = dir_q;
  assign active  = !(nxt inside {ST_IDLE, ST_CTYPE, ST_CHAN});
  assign sel     = (state_q == ST_CHAN) ? lad_in[2:0] : chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      dir_q     <= 1'b0;
      tc_q      <= 1'b0;
      two_q     <= 1'b0;
      chan_q    <= '0;
      done_q    <= '0;
      sync_ok_q <= 1'b0;
    end else begin
      state_q   <= nxt;
      sync_ok_q <= take;
      if (state_q == ST_CTYPE) dir_q <= lad_in[1];
      if (state_q == ST_CHAN) begin
        tc_q   <= lad_in[3];
        chan_q <= lad_in[2:0];
      end
      if (state_q == ST_SIZE) begin
        two_q  <= lad_in[0];
        done_q <= '0;
      end else if (state_q == ST_SYNC && sync_ok_q && lframe_n) begin
        done_q <= done_q + 2'd1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ack
    always_ff @(posedge clk) begin
      if (rst) chan_ack[g] <= 1'b0;
      else     chan_ack[g] <= active && (sel == FW'(g));
    end
  end

  assert_chan_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chan_ack));
  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !lframe_n |=> (state_q == ST_IDLE || state_q == ST_CTYPE));
endmodule

// File: rtl/lpc_dma_rx_asm.sv
module lpc_dma_rx_asm import lpc_dma_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  lpc_st_e    state,
  input  logic [3:0] lad_in,
  input  logic       take,
  input  logic       dir_wr,
  input  logic       last_tc,
  output logic       rx_push,
  output logic [7:0] rx_data,
  output logic       rx_tc
);
  logic [3:0] nib_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_lo  <= '0;
      rx_data <= '0;
      rx_push <= 1'b0;
      rx_tc   <= 1'b0;
    end else begin
      if (state == ST_HDL) nib_lo  <= lad_in;
      if (state == ST_HDH) rx_data <= {lad_in, nib_lo};
      rx_push <= take && !dir_wr;
      rx_tc   <= take && !dir_wr && last_tc;
    end
  end

  assert_tc_with_push_R10: assert property (@(posedge clk) disable iff (rst)
    rx_tc |-> rx_push);
endmodule

// File: rtl/lpc_dma_lad_drv.sv
module lpc_dma_lad_drv import lpc_dma_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       lframe_n,
  input  lpc_st_e    state,
  input  lpc_st_e    nxt,
  input  logic       take,
  input  logic       dir_wr,
  input  logic       last_tc,
  input  logic [7:0] tx_data,
  output logic [3:0] lad_out,
  output logic       lad_oe,
  output logic       tx_pop,
  output logic       tx_tc
);
  logic [7:0] txb;

  always_ff @(posedge clk) begin
    if (rst) begin
      lad_out <= NIB_TURN;
      lad_oe  <= 1'b0;
      tx_pop  <= 1'b0;
      tx_tc   <= 1'b0;
      txb     <= '0;
    end else begin
      tx_pop <= take && dir_wr;
      tx_tc  <= take && dir_wr && last_tc;
      if (take && dir_wr) txb <= tx_data;
      case (nxt)
        ST_SYNC: begin lad_oe <= 1'b1; lad_out <= take ? SYNC_READY : SYNC_SWAIT; end
        ST_PDL:  begin lad_oe <= 1'b1; lad_out <= txb[3:0]; end
        ST_PDH:  begin lad_oe <= 1'b1; lad_out <= txb[7:4]; end
        ST_PTA1: begin lad_oe <= 1'b1; lad_out <= NIB_TURN; end
        default: begin lad_oe <= 1'b0; lad_out <= NIB_TURN; end
      endcase
    end
  end

  assert_pop_in_ready_sync_R8: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> (lad_oe && lad_out == SYNC_READY));
  assert_release_on_frame_R11: assert property (@(posedge clk) disable iff (rst)
    !lframe_n |=> !lad_oe);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (!lad_oe && !tx_pop));
endmodule

// File: rtl/lpc_dma_periph.sv
module lpc_dma_periph import lpc_dma_pkg::*; #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lframe_n,
  input  logic [3:0]     lad_in,
  output logic [3:0]     lad_out,
  output logic           lad_oe,
  input  logic           rx_ready,
  output logic           rx_push,
  output logic [7:0]     rx_data,
  output logic           rx_tc,
  input  logic           tx_valid,
  input  logic [7:0]     tx_data,
  output logic           tx_pop,
  output logic           tx_tc,
  output logic [NCH-1:0] chan_ack
);
  lpc_st_e state, nxt;
  logic    take, dir_wr, last_tc;

  lpc_dma_fsm #(.NCH(NCH)) u_fsm (
    .clk(clk), .rst(rst), .lframe_n(lframe_n), .lad_in(lad_in),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .state(state), .nxt(nxt),
    .take(take), .dir_wr(dir_wr), .last_tc(last_tc), .chan_ack(chan_ack)
  );

  lpc_dma_rx_asm u_rx (
    .clk(clk), .rst(rst), .state(state), .lad_in(lad_in), .take(take),
    .dir_wr(dir_wr), .last_tc(last_tc), .rx_push(rx_push),
    .rx_data(rx_data), .rx_tc(rx_tc)
  );

  lpc_dma_lad_drv u_drv (
    .clk(clk), .rst(rst), .lframe_n(lframe_n), .state(state), .nxt(nxt),
    .take(take), .dir_wr(dir_wr), .last_tc(last_tc), .tx_data(tx_data),
    .lad_out(lad_out), .lad_oe(lad_oe), .tx_pop(tx_pop), .tx_tc(tx_tc)
  );
endmodule

// File: tb/lpc_dma_periph_tb.sv
module lpc_dma_periph_tb;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           lframe_n = 1'b1;
  logic [3:0]     lad_in = 4'hF;
  logic [3:0]     lad_out;
  logic           lad_oe;
  logic           rx_ready = 1'b1;
  logic           rx_push;
  logic [7:0]     rx_data;
  logic           rx_tc;
  logic           tx_valid = 1'b0;
  logic [7:0]     tx_data = 8'h00;
  logic           tx_pop;
  logic           tx_tc;
  logic [NCH-1:0] chan_ack;

  int nchk = 0;
  int nerr = 0;
  int npush = 0;
  int npop = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  lpc_dma_periph #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .lframe_n(lframe_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .rx_ready(rx_ready),
    .rx_push(rx_push), .rx_data(rx_data), .rx_tc(rx_tc),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
    .tx_tc(tx_tc), .chan_ack(chan_ack)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && rx_push) npush <= npush + 1;
    if (!rst && tx_pop)  npop  <= npop + 1;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      nerr = nerr + 1;
      nchk = nchk + 1;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nerr = nerr + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic lf, input logic [3:0] n);
    @(negedge clk);
    lframe_n = lf;
    lad_in   = n;
  endtask

  task automatic hdr(input logic [3:0] ct, input logic [3:0] chf, input logic [3:0] sz);
    step(1'b0, 4'h0);
    step(1'b1, ct);
    step(1'b1, chf);
    step(1'b1, sz);
  endtask

  task automatic t_reset();
    chk("R1 reset lad_oe", {15'b0, lad_oe}, 16'h0);
    chk("R1 reset strobes", {13'b0, rx_push, tx_pop, rx_tc}, 16'h0);
    chk("R1 reset chan_ack", {12'b0, chan_ack}, 16'h0);
  endtask

  task automatic t_read8(input logic [7:0] b, input logic tc, input logic [2:0] ch, input string tag);
    rx_ready = 1'b1;
    hdr(4'h8, {tc, ch}, 4'h0);
    step(1'b1, b[3:0]);
    chk({tag, " R4 chan_ack"}, {12'b0, chan_ack}, 16'(1 << ch));
    step(1'b1, b[7:4]);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    chk({tag, " R6 sync"}, {11'b0, lad_oe, lad_out}, 16'h10);
    chk({tag, " R6 push data"}, {7'b0, rx_push, rx_data}, {7'b0, 1'b1, b});
    chk({tag, " R10 tc single"}, {15'b0, rx_tc}, {15'b0, tc});
    step(1'b1, 4'hF);
    chk({tag, " R9 turn drive"}, {11'b0, lad_oe, lad_out}, 16'h1F);
    step(1'b1, 4'hF);
    chk({tag, " R9 release"}, {15'b0, lad_oe}, 16'h0);
    step(1'b1, 4'hF);
    chk({tag, " R1 idle ack"}, {12'b0, chan_ack}, 16'h0);
  endtask

  task automatic t_read16_wait();
    rx_ready = 1'b0;
    hdr(4'h8, 4'h9, 4'h1);
    step(1'b1, 4'hC);
    step(1'b1, 4'h3);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    chk("R7 rx wait sync", {11'b0, lad_oe, lad_out}, 16'h15);
    chk("R7 no push in wait", {15'b0, rx_push}, 16'h0);
    step(1'b1, 4'hF);
    chk("R7 rx wait sync 2", {11'b0, lad_oe, lad_out}, 16'h15);
    rx_ready = 1'b1;
    step(1'b1, 4'hF);
    chk("R6 16b first push", {7'b0, rx_push, rx_data}, 16'h13C);
    chk("R10 no tc first byte", {15'b0, rx_tc}, 16'h0);
    step(1'b1, 4'hF);
    chk("R9 16b turn", {11'b0, lad_oe, lad_out}, 16'h1F);
    step(1'b1, 4'hF);
    chk("R9 16b release", {15'b0, lad_oe}, 16'h0);
    step(1'b1, 4'h1);
    step(1'b1, 4'hE);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    chk("R6 16b second sync", {11'b0, lad_oe, lad_out}, 16'h10);
    chk("R6 16b second push", {7'b0, rx_push, rx_data}, 16'h1E1);
    chk("R10 tc last byte", {15'b0, rx_tc}, 16'h1);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    chk("R9 16b final release", {15'b0, lad_oe}, 16'h0);
  endtask

  task automatic t_write8();
    tx_valid = 1'b1;
    tx_data  = 8'h5A;
    hdr(4'hA, 4'h3, 4'h0);
    chk("R4 write ack", {12'b0, chan_ack}, 16'h8);
    step(1'b1, 4'hF);
    chk("R8 host turn not driven", {15'b0, lad_oe}, 16'h0);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    chk("R8 write sync", {11'b0, lad_oe, lad_out}, 16'h10);
    chk("R8 pop", {14'b0, tx_pop, tx_tc}, 16'h2);
    tx_valid = 1'b0;
    step(1'b1, 4'hF);
    chk("R8 low nibble", {11'b0, lad_oe, lad_out}, 16'h1A);
    step(1'b1, 4'hF);
    chk("R8 high nibble", {11'b0, lad_oe, lad_out}, 16'h15);
    step(1'b1, 4'hF);
    chk("R9 write turn", {11'b0, lad_oe, lad_out}, 16'h1F);
    step(1'b1, 4'hF);
    chk("R9 write release", {15'b0, lad_oe}, 16'h0);
  endtask

  task automatic t_write16_wait();
    int p0;
    p0 = npop;
    tx_valid = 1'b1;
    tx_data  = 8'h96;
    hdr(4'hA, 4'h8, 4'h1);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    chk("R8 16b first pop", {14'b0, tx_pop, tx_tc}, 16'h2);
    tx_valid = 1'b0;
    tx_data  = 8'h47;
    step(1'b1, 4'hF);
    chk("R8 16b byte1 low", {11'b0, lad_oe, lad_out}, 16'h16);
    step(1'b1, 4'hF);
    chk("R8 16b byte1 high", {11'b0, lad_oe, lad_out}, 16'h19);
    step(1'b1, 4'hF);
    chk("R7 tx wait sync", {11'b0, lad_oe, lad_out}, 16'h15);
    tx_valid = 1'b1;
    step(1'b1, 4'hF);
    chk("R10 tc on second pop", {14'b0, tx_pop, tx_tc}, 16'h3);
    tx_valid = 1'b0;
    step(1'b1, 4'hF);
    chk("R8 16b byte2 low", {11'b0, lad_oe, lad_out}, 16'h17);
    step(1'b1, 4'hF);
    chk("R8 16b byte2 high", {11'b0, lad_oe, lad_out}, 16'h14);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    chk("R9 16b write release", {15'b0, lad_oe}, 16'h0);
    chk("R8 two pops", 16'(npop - p0), 16'd2);
  endtask

  task automatic t_ignored(input logic [3:0] ct, input logic [3:0] chf, input logic [3:0] sz, input string tag);
    int p0;
    int drove;
    p0 = npush;
    drove = 0;
    rx_ready = 1'b1;
    hdr(ct, chf, sz);
    for (int i = 0; i < 10; i++) begin
      step(1'b1, (i < 2) ? 4'h7 : 4'hF);
      if (lad_oe || chan_ack != 0) drove = drove + 1;
    end
    chk({tag, " no drive"}, 16'(drove), 16'd0);
    chk({tag, " no push"}, 16'(npush - p0), 16'd0);
  endtask

  task automatic t_abort_read();
    int p0;
    p0 = npush;
    rx_ready = 1'b1;
    hdr(4'h8, 4'h0, 4'h0);
    step(1'b1, 4'h4);
    step(1'b0, 4'h3);
    step(1'b1, 4'h6);
    chk("R11 abort released", {15'b0, lad_oe}, 16'h0);
    for (int i = 0; i < 6; i++) step(1'b1, 4'hF);
    chk("R11 partial byte dropped", 16'(npush - p0), 16'd0);
  endtask

  task automatic t_abort_write();
    int p0;
    p0 = npop;
    tx_valid = 1'b0;
    hdr(4'hA, 4'h1, 4'h0);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    step(1'b0, 4'h7);
    chk("R7 wait before abort", {11'b0, lad_oe, lad_out}, 16'h15);
    step(1'b1, 4'hF);
    chk("R11 write abort released", {15'b0, lad_oe}, 16'h0);
    tx_valid = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 4'hF);
    chk("R11 no pop after abort", 16'(npop - p0), 16'd0);
    tx_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read8(8'hA5, 1'b1, 3'd2, "read8");
    t_read8(8'h0F, 1'b0, 3'd0, "read8 notc");
    t_read16_wait();
    t_write8();
    t_write16_wait();
    t_ignored(4'h0, 4'h1, 4'h0, "R3 non-dma type");
    t_ignored(4'h8, 4'h6, 4'h0, "R4 unserved channel");
    t_ignored(4'h8, 4'h1, 4'h2, "R5 bad size");
    t_abort_read();
    t_abort_write();
    step(1'b0, 4'h3);
    t_read8(8'hC3, 1'b0, 3'd3, "R2 start after held frame");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule